// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks every instruction between rename and retirement in an out-of-order core. Rename writes up to two new entries per cycle at the tail of a circular buffer. The execution units report completions by entry tag, up to three per cycle. Each cycle the block retires finished entries from the head in program order. For each retired entry it updates a committed architectural-to-physical register map and releases the physical register that the entry superseded.

Some entries end a retire pass early. A store is handed to the store buffer one per cycle, and the pass ends after it. A mispredicted branch raises a flush with its redirect address, and the pass ends after it. The pass also ends once three speculative branches have retired in it. A faulted entry at the retire point raises halt and stays in the buffer. The free-entry count is output so that rename can stall before the buffer fills.

Top module: `robq_top`

## Requirements
- R1: After reset the free count equals the depth (16), the tail is 0, flush, halt, the store strobe and all release strobes are low, and the committed map sends architectural register i to physical register i.
- R2: Up to two entries are written per cycle. Valid slots are packed from the current tail in slot order, so slot 1 alone takes the tail position. The tail output advances by the number of valid slots.
- R3: Entries retire strictly in program order. An unfinished entry at the head blocks every younger entry, including finished ones.
- R4: One retire pass examines at most six consecutive entries from the head. The free count output equals depth minus occupancy, and it rises in the cycle after the retirement is decided.
- R5: A retiring entry with a valid destination writes its new physical register into the committed map at its architectural index. When its previous physical register is nonzero, that register appears on the release port at the entry's slot position in the pass (slot 0 = head).
- R6: A retire pass ends right after the third speculative-branch entry it retires.
- R7: A retiring store raises the store strobe for one cycle with the store's tag. No younger entry retires in that pass.
- R8: A retiring mispredicted entry raises flush with its redirect PC and still commits its destination. All younger entries are discarded, the tail is set equal to the new head, and the free count returns to the depth.
- R9: A finished faulted entry reached by a pass raises halt. That entry does not retire, so halt stays high in the following cycles.
- R10: A completion marks its entry finished and records the redirect PC and the taken flag. The fault flag is ORed in. The entry counts as mispredicted only when the operation is a jump and its predicted direction differs from the actual one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 2 | Per-slot new-entry valid |
| enq_spec | input | 2 | Entry is a speculative branch |
| enq_store | input | 2 | Entry is a store |
| enq_dst_v | input | 2 | Entry writes a destination register |
| enq_adst | input | 10 | Architectural destinations, 5 bits per slot |
| enq_new_p | input | 12 | New physical destinations, 6 bits per slot |
| enq_prev_p | input | 12 | Superseded physical registers, 6 bits per slot |
| cpl_valid | input | 3 | Completion report valid |
| cpl_tag | input | 12 | Entry tag per report, 4 bits each |
| cpl_taken | input | 3 | Actual branch direction |
| cpl_pred | input | 3 | Predicted branch direction |
| cpl_jump | input | 3 | Report belongs to a jump |
| cpl_fault | input | 3 | Operation faulted |
| cpl_pc | input | 96 | Redirect PC per report, 32 bits each |
| tail_ptr | output | 4 | Tag given to the next allocated entry |
| free_cnt | output | 5 | Free entries |
| rel_valid | output | 6 | Release strobe per retire slot |
| rel_preg | output | 36 | Released physical register per slot |
| st_valid | output | 1 | Store retire strobe |
| st_tag | output | 4 | Tag of the retiring store |
| flush | output | 1 | Misprediction flush |
| flush_pc | output | 32 | Redirect PC for the flush |
| halt | output | 1 | Fault reached at retirement |
| commit_map | output | 192 | Committed map, 6 bits per architectural register |

## Verification
The bench builds the block with its defaults: 16 entries, two allocation slots, three completion ports, a six-entry retire window and a cap of three speculative branches per pass. With 16 entries the pointers wrap many times during the random phase. The six-entry window is small enough that one directed case fills eight finished entries and sees the window cap split them over two cycles. The three-branch cap is reached with five speculative entries. A cycle-level model built from the requirements checks all outputs and the whole committed map every cycle.

// File: rtl/robq_pkg.sv
package robq_pkg;
  localparam int AREG_W = 5;
  localparam int PREG_W = 6;
  localparam int PC_W   = 32;

  typedef struct packed {
    logic              finished;
    logic              spec;
    logic              store;
    logic              dst_v;
    logic [AREG_W-1:0] adst;
    logic [PREG_W-1:0] prev_p;
    logic [PREG_W-1:0] new_p;
    logic              mispred;
    logic [PC_W-1:0]   redir_pc;
    logic              fault;
    logic              taken;
  } rob_ent_t;
endpackage

// File: rtl/robq_retire_scan.sv
module robq_retire_scan
  import robq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SCAN     = 6,
  parameter int SPEC_MAX = 3,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int RN_W    = $clog2(SCAN + 1)
) (
  input  rob_ent_t          ent [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [CNT_W-1:0]  occ,
  output rob_ent_t          slot_ent [SCAN],
  output logic [SCAN-1:0]   ret_mask,
  output logic [RN_W-1:0]   ret_n,
  output logic              do_flush,
  output logic [PC_W-1:0]   scan_pc,
  output logic              do_store,
  output logic [PTR_W-1:0]  store_tag,
  output logic              do_halt
);
  // window of consecutive entries starting at the head
  for (genvar s = 0; s < SCAN; s++) begin : g_win
    assign slot_ent[s] = ent[head + PTR_W'(s)];
  end

  always_comb begin
    logic stop;
    int   spec_seen;
    stop      = 1'b0;
    spec_seen = 0;
    ret_mask  = '0;
    ret_n     = '0;
    do_flush  = 1'b0;
    scan_pc   = '0;
    do_store  = 1'b0;
    store_tag = '0;
    do_halt   = 1'b0;
    for (int s = 0; s < SCAN; s++) begin
      if (!stop) begin
        if ((CNT_W'(s) >= occ) || !slot_ent[s].finished) begin
          stop = 1'b1;
        end else if (slot_ent[s].fault) begin
          do_halt = 1'b1;
          stop    = 1'b1;
        end else begin
          ret_mask[s] = 1'b1;
          ret_n       = ret_n + RN_W'(1);
          if (slot_ent[s].spec) spec_seen = spec_seen + 1;
          if (slot_ent[s].store) begin
            do_store  = 1'b1;
            store_tag = head + PTR_W'(s);
            stop      = 1'b1;
          end
          if (slot_ent[s].mispred) begin
            do_flush = 1'b1;
            scan_pc  = slot_ent[s].redir_pc;
            stop     = 1'b1;
          end
          if (spec_seen == SPEC_MAX) stop = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/robq_commit_map.sv
module robq_commit_map
  import robq_pkg::*;
#(
  parameter int SCAN   = 6,
  localparam int NAREG = 1 << AREG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [SCAN-1:0]          wr_en,
  input  logic [SCAN*AREG_W-1:0]   wr_areg,
  input  logic [SCAN*PREG_W-1:0]   wr_preg,
  output logic [NAREG*PREG_W-1:0]  map_flat
);
  // later slots are younger, so they are applied last and win
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NAREG; i++)
        map_flat[i*PREG_W +: PREG_W] <= PREG_W'(i);
    end else begin
      for (int s = 0; s < SCAN; s++)
        if (wr_en[s])
          map_flat[wr_areg[s*AREG_W +: AREG_W]*PREG_W +: PREG_W] <= wr_preg[s*PREG_W +: PREG_W];
    end
  end
endmodule

// File: rtl/robq_top.sv
module robq_top
  import robq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int ENQ      = 2,
  parameter int CPL      = 3,
  parameter int SCAN     = 6,
  parameter int SPEC_MAX = 3,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = PTR_W + 1,
  localparam int NAREG   = 1 << AREG_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ENQ-1:0]           enq_valid,
  input  logic [ENQ-1:0]           enq_spec,
  input  logic [ENQ-1:0]           enq_store,
  input  logic [ENQ-1:0]           enq_dst_v,
  input  logic [ENQ*AREG_W-1:0]    enq_adst,
  input  logic [ENQ*PREG_W-1:0]    enq_new_p,
  input  logic [ENQ*PREG_W-1:0]    enq_prev_p,
  input  logic [CPL-1:0]           cpl_valid,
  input  logic [CPL*PTR_W-1:0]     cpl_tag,
  input  logic [CPL-1:0]           cpl_taken,
  input  logic [CPL-1:0]           cpl_pred,
  input  logic [CPL-1:0]           cpl_jump,
  input  logic [CPL-1:0]           cpl_fault,
  input  logic [CPL*PC_W-1:0]      cpl_pc,
  output logic [PTR_W-1:0]         tail_ptr,
  output logic [CNT_W-1:0]         free_cnt,
  output logic [SCAN-1:0]          rel_valid,
  output logic [SCAN*PREG_W-1:0]   rel_preg,
  output logic                     st_valid,
  output logic [PTR_W-1:0]         st_tag,
  output logic                     flush,
  output logic [PC_W-1:0]          flush_pc,
  output logic                     halt,
  output logic [NAREG*PREG_W-1:0]  commit_map
);
  localparam int RN_W = $clog2(SCAN + 1);
  localparam int EN_W = $clog2(ENQ + 1);

  rob_ent_t          ent [DEPTH];
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  occ;

  rob_ent_t          slot_ent [SCAN];
  logic [SCAN-1:0]   ret_mask;
  logic [RN_W-1:0]   ret_n;
  logic              do_flush, do_store, do_halt;
  logic [PC_W-1:0]   scan_pc;
  logic [PTR_W-1:0]  store_tag;

  robq_retire_scan #(.DEPTH(DEPTH), .SCAN(SCAN), .SPEC_MAX(SPEC_MAX)) u_scan (
    .ent(ent), .head(head), .occ(occ), .slot_ent(slot_ent),
    .ret_mask(ret_mask), .ret_n(ret_n), .do_flush(do_flush), .scan_pc(scan_pc),
    .do_store(do_store), .store_tag(store_tag), .do_halt(do_halt)
  );

  // committed map write ports, one per retire slot
  logic [SCAN-1:0]        map_we;
  logic [SCAN*AREG_W-1:0] map_areg;
  logic [SCAN*PREG_W-1:0] map_preg;
  logic [SCAN-1:0]        slot_spec;
  logic [SCAN-1:0]        unused_slot_bits;
  for (genvar s = 0; s < SCAN; s++) begin : g_slot
    assign map_we[s]                   = ret_mask[s] & slot_ent[s].dst_v;
    assign map_areg[s*AREG_W +: AREG_W] = slot_ent[s].adst;
    assign map_preg[s*PREG_W +: PREG_W] = slot_ent[s].new_p;
    assign slot_spec[s]                = slot_ent[s].spec;
    assign unused_slot_bits[s] = ^{slot_ent[s].taken, slot_ent[s].finished, slot_ent[s].store,
                                   slot_ent[s].mispred, slot_ent[s].redir_pc, slot_ent[s].fault};
  end

  robq_commit_map #(.SCAN(SCAN)) u_map (
    .clk(clk), .rst(rst), .wr_en(map_we), .wr_areg(map_areg),
    .wr_preg(map_preg), .map_flat(commit_map)
  );

  // allocation: valid slots are packed from the tail
  logic [PTR_W-1:0] enq_pos [ENQ];
  logic [EN_W-1:0]  enq_n;
  rob_ent_t         enq_ent [ENQ];
  always_comb begin
    enq_n = '0;
    for (int k = 0; k < ENQ; k++) begin
      enq_pos[k]        = tail + PTR_W'(enq_n);
      enq_ent[k]        = '0;
      enq_ent[k].spec   = enq_spec[k];
      enq_ent[k].store  = enq_store[k];
      enq_ent[k].dst_v  = enq_dst_v[k];
      enq_ent[k].adst   = enq_adst[k*AREG_W +: AREG_W];
      enq_ent[k].new_p  = enq_new_p[k*PREG_W +: PREG_W];
      enq_ent[k].prev_p = enq_prev_p[k*PREG_W +: PREG_W];
      if (enq_valid[k]) enq_n = enq_n + EN_W'(1);
    end
  end

  logic [CNT_W-1:0] occ_nxt;
  assign occ_nxt  = occ + CNT_W'(enq_n) - CNT_W'(ret_n);
  assign free_cnt = CNT_W'(DEPTH) - occ;
  assign tail_ptr = tail;

  always_ff @(posedge clk) begin
    if (rst) begin
      head      <= '0;
      tail      <= '0;
      occ       <= '0;
      rel_valid <= '0;
      rel_preg  <= '0;
      st_valid  <= 1'b0;
      st_tag    <= '0;
      flush     <= 1'b0;
      flush_pc  <= '0;
      halt      <= 1'b0;
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else begin
      head     <= head + PTR_W'(ret_n);
      st_valid <= do_store;
      st_tag   <= store_tag;
      flush    <= do_flush;
      flush_pc <= scan_pc;
      halt     <= do_halt;
      for (int s = 0; s < SCAN; s++) begin
        rel_valid[s] <= map_we[s] & (slot_ent[s].prev_p != '0);
        rel_preg[s*PREG_W +: PREG_W] <= slot_ent[s].prev_p;
      end
      if (do_flush) begin
        tail <= head + PTR_W'(ret_n);
        occ  <= '0;
        for (int i = 0; i < DEPTH; i++) ent[i].finished <= 1'b0;
      end else begin
        for (int c = 0; c < CPL; c++) begin
          if (cpl_valid[c]) begin
            ent[cpl_tag[c*PTR_W +: PTR_W]].finished <= 1'b1;
            ent[cpl_tag[c*PTR_W +: PTR_W]].taken    <= cpl_taken[c];
            ent[cpl_tag[c*PTR_W +: PTR_W]].redir_pc <= cpl_pc[c*PC_W +: PC_W];
            ent[cpl_tag[c*PTR_W +: PTR_W]].fault    <= ent[cpl_tag[c*PTR_W +: PTR_W]].fault | cpl_fault[c];
            ent[cpl_tag[c*PTR_W +: PTR_W]].mispred  <= cpl_jump[c] & (cpl_pred[c] != cpl_taken[c]);
          end
        end
        for (int k = 0; k < ENQ; k++)
          if (enq_valid[k]) ent[enq_pos[k]] <= enq_ent[k];
        tail <= tail + PTR_W'(enq_n);
        occ  <= occ_nxt;
      end
    end
  end

  // R2: allocation never exceeds the room left after this cycle's retirement
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(enq_n) <= free_cnt + CNT_W'(ret_n));
  // R3: retired slots form an unbroken run from the head
  a_r3_in_order: assert property (@(posedge clk) disable iff (rst)
    ((ret_mask + SCAN'(1)) & ret_mask) == '0);
  // R6: speculative branches retired per pass are capped
  a_r6_spec_cap: assert property (@(posedge clk) disable iff (rst)
    $countones(ret_mask & slot_spec) <= SPEC_MAX);
  // R7: a store pass and a flush pass never coincide
  a_r7_store_not_flush: assert property (@(posedge clk) disable iff (rst)
    !(st_valid && flush));
  // R8: a flush leaves the buffer empty
  a_r8_flush_drains: assert property (@(posedge clk) disable iff (rst)
    flush |-> free_cnt == CNT_W'(DEPTH));
  // R9: a faulted entry stays at the retire point
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);
  for (genvar s = 0; s < SCAN; s++) begin : g_rel_chk
    // R5: register 0 is never released
    a_r5_no_zero_release: assert property (@(posedge clk) disable iff (rst)
      rel_valid[s] |-> rel_preg[s*PREG_W +: PREG_W] != '0);
  end
endmodule

// File: tb/robq_top_bench.sv
module robq_top_bench;
  localparam int D = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]   enq_valid, enq_spec, enq_store, enq_dst_v;
  logic [9:0]   enq_adst;
  logic [11:0]  enq_new_p, enq_prev_p;
  logic [2:0]   cpl_valid, cpl_taken, cpl_pred, cpl_jump, cpl_fault;
  logic [11:0]  cpl_tag;
  logic [95:0]  cpl_pc;
  logic [3:0]   tail_ptr, st_tag;
  logic [4:0]   free_cnt;
  logic [5:0]   rel_valid;
  logic [35:0]  rel_preg;
  logic         st_valid, flush, halt;
  logic [31:0]  flush_pc;
  logic [191:0] commit_map;

  robq_top u_robq_top (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_spec(enq_spec), .enq_store(enq_store),
    .enq_dst_v(enq_dst_v), .enq_adst(enq_adst), .enq_new_p(enq_new_p), .enq_prev_p(enq_prev_p),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_taken(cpl_taken), .cpl_pred(cpl_pred),
    .cpl_jump(cpl_jump), .cpl_fault(cpl_fault), .cpl_pc(cpl_pc), .tail_ptr(tail_ptr),
    .free_cnt(free_cnt), .rel_valid(rel_valid), .rel_preg(rel_preg), .st_valid(st_valid),
    .st_tag(st_tag), .flush(flush), .flush_pc(flush_pc), .halt(halt), .commit_map(commit_map)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference model state
  int m_head, m_tail, m_cnt;
  bit m_fin[D], m_spec[D], m_store[D], m_dv[D], m_mis[D], m_flt[D];
  int m_ad[D], m_np[D], m_pp[D];
  bit [31:0] m_pc[D];
  int m_map[32];
  bit e_flush, e_st, e_halt;
  bit [31:0] e_pc;
  int e_sttag;
  bit [5:0] e_relv;
  int e_relp[6];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    enq_valid = '0; enq_spec = '0; enq_store = '0; enq_dst_v = '0;
    enq_adst = '0; enq_new_p = '0; enq_prev_p = '0;
    cpl_valid = '0; cpl_tag = '0; cpl_taken = '0; cpl_pred = '0;
    cpl_jump = '0; cpl_fault = '0; cpl_pc = '0;
  endtask

  task automatic put_enq(int k, bit sp, bit st, bit dv, int ad, int np, int pp);
    enq_valid[k] = 1'b1; enq_spec[k] = sp; enq_store[k] = st; enq_dst_v[k] = dv;
    enq_adst[k*5 +: 5] = 5'(ad); enq_new_p[k*6 +: 6] = 6'(np); enq_prev_p[k*6 +: 6] = 6'(pp);
  endtask

  task automatic put_cpl(int c, int tag, bit tk, bit pr, bit jp, bit flt, bit [31:0] pc);
    cpl_valid[c] = 1'b1; cpl_tag[c*4 +: 4] = 4'(tag); cpl_taken[c] = tk; cpl_pred[c] = pr;
    cpl_jump[c] = jp; cpl_fault[c] = flt; cpl_pc[c*32 +: 32] = pc;
  endtask

  task automatic model_reset();
    m_head = 0; m_tail = 0; m_cnt = 0;
    for (int i = 0; i < D; i++) begin
      m_fin[i] = 0; m_flt[i] = 0; m_mis[i] = 0;
    end
    for (int i = 0; i < 32; i++) m_map[i] = i;
  endtask

  // one cycle of the requirements applied to the model with the driven inputs
  task automatic model_cycle();
    int rn, specs, n, slot;
    bit stop;
    rn = 0; specs = 0; stop = 0;
    e_flush = 0; e_st = 0; e_halt = 0; e_relv = '0; e_pc = '0; e_sttag = 0;
    for (int s = 0; s < 6; s++) begin
      int t;
      t = (m_head + s) & 15;
      if (!stop) begin
        if (s >= m_cnt || !m_fin[t]) stop = 1;
        else if (m_flt[t]) begin e_halt = 1; stop = 1; end
        else begin
          rn++;
          if (m_dv[t]) begin
            m_map[m_ad[t]] = m_np[t];
            if (m_pp[t] != 0) begin e_relv[s] = 1; e_relp[s] = m_pp[t]; end
          end
          if (m_spec[t]) specs++;
          if (m_store[t]) begin e_st = 1; e_sttag = t; stop = 1; end
          if (m_mis[t]) begin e_flush = 1; e_pc = m_pc[t]; stop = 1; end
          if (specs == 3) stop = 1;
        end
      end
    end
    m_head = (m_head + rn) & 15;
    if (e_flush) begin
      m_tail = m_head; m_cnt = 0;
      for (int i = 0; i < D; i++) m_fin[i] = 0;
    end else begin
      for (int c = 0; c < 3; c++) if (cpl_valid[c]) begin
        int t;
        t = int'(cpl_tag[c*4 +: 4]);
        m_fin[t] = 1; m_pc[t] = cpl_pc[c*32 +: 32];
        m_flt[t] = m_flt[t] | cpl_fault[c];
        m_mis[t] = cpl_jump[c] && (cpl_pred[c] != cpl_taken[c]);
      end
      n = 0;
      for (int k = 0; k < 2; k++) if (enq_valid[k]) begin
        slot = (m_tail + n) & 15;
        m_fin[slot] = 0; m_mis[slot] = 0; m_flt[slot] = 0;
        m_spec[slot] = enq_spec[k]; m_store[slot] = enq_store[k]; m_dv[slot] = enq_dst_v[k];
        m_ad[slot] = int'(enq_adst[k*5 +: 5]); m_np[slot] = int'(enq_new_p[k*6 +: 6]);
        m_pp[slot] = int'(enq_prev_p[k*6 +: 6]);
        n++;
      end
      m_tail = (m_tail + n) & 15;
      m_cnt = m_cnt + n - rn;
    end
  endtask

  task automatic compare();
    int bad_i;
    chk(free_cnt == 5'(D - m_cnt), "R4", "free_cnt", free_cnt, D - m_cnt);
    chk(tail_ptr == 4'(m_tail), "R2", "tail_ptr", tail_ptr, m_tail);
    chk(flush == e_flush, "R8", "flush", flush, e_flush);
    if (e_flush) chk(flush_pc == e_pc, "R8", "flush_pc", flush_pc, e_pc);
    chk(st_valid == e_st, "R7", "st_valid", st_valid, e_st);
    if (e_st) chk(st_tag == 4'(e_sttag), "R7", "st_tag", st_tag, e_sttag);
    chk(halt == e_halt, "R9", "halt", halt, e_halt);
    chk(rel_valid == e_relv, "R5", "rel_valid", rel_valid, e_relv);
    for (int s = 0; s < 6; s++)
      if (e_relv[s]) chk(rel_preg[s*6 +: 6] == 6'(e_relp[s]), "R5", "rel_preg", rel_preg[s*6 +: 6], e_relp[s]);
    bad_i = -1;
    for (int i = 0; i < 32; i++)
      if (bad_i < 0 && commit_map[i*6 +: 6] != 6'(m_map[i])) bad_i = i;
    if (bad_i < 0) chk(1'b1, "R5", "commit_map", 0, 0);
    else chk(1'b0, "R5", "commit_map entry", commit_map[bad_i*6 +: 6], m_map[bad_i]);
  endtask

  task automatic step();
    model_cycle();
    @(posedge clk);
    #2;
    compare();
    clear_in();
  endtask

  task automatic gen_random(bit allow_enq);
    int n;
    clear_in();
    if (allow_enq && m_cnt + 2 <= D) begin
      for (int k = 0; k < 2; k++) if ($urandom % 3 != 0) begin
        bit sp, st, dv;
        sp = ($urandom % 3 == 0);
        st = !sp && ($urandom % 5 == 0);
        dv = !st && ($urandom % 4 != 0);
        put_enq(k, sp, st, dv, $urandom % 32, 1 + $urandom % 63, ($urandom % 4 == 0) ? 0 : $urandom % 64);
      end
    end
    n = 0;
    for (int s = 0; s < m_cnt; s++) begin
      int t;
      t = (m_head + s) & 15;
      if (n < 3 && !m_fin[t] && ($urandom % 2 == 1)) begin
        bit tk;
        tk = $urandom % 2;
        put_cpl(n, t, tk, ($urandom % 8 == 0) ? !tk : tk, m_spec[t], 1'b0, $urandom);
        n++;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "R4", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    int b, snap8;
    void'($urandom(32'd20240611));
    clear_in();
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;

    // R1: reset state
    chk(free_cnt == 5'd16, "R1", "free_cnt", free_cnt, 16);
    chk(tail_ptr == 4'd0, "R1", "tail_ptr", tail_ptr, 0);
    chk(!flush && !halt && !st_valid, "R1", "strobes", {flush, halt, st_valid}, 0);
    chk(rel_valid == 6'd0, "R1", "rel_valid", rel_valid, 0);
    compare();

    // R3: unfinished head blocks finished younger entries
    b = m_head;
    put_enq(0, 0, 0, 1, 3, 20, 4); put_enq(1, 0, 0, 1, 4, 21, 5); step();
    put_enq(1, 0, 0, 1, 5, 22, 6); step();
    put_enq(0, 0, 0, 1, 6, 23, 0); step();
    chk(tail_ptr == 4'((b + 4) & 15), "R2", "tail after packed slot 1", tail_ptr, (b + 4) & 15);
    put_cpl(0, (b+1)&15, 0, 0, 0, 0, 0); put_cpl(1, (b+2)&15, 0, 0, 0, 0, 0); put_cpl(2, (b+3)&15, 0, 0, 0, 0, 0);
    step(); step();
    chk(free_cnt == 5'd12, "R3", "blocked by head", free_cnt, 12);
    put_cpl(0, b, 0, 0, 0, 0, 0); step(); step();
    chk(free_cnt == 5'd16, "R3", "drained after head", free_cnt, 16);

    // R4: eight finished entries, window of six
    b = m_head;
    for (int i = 0; i < 4; i++) begin
      put_enq(0, 0, 0, 1, 10 + 2*i, 30 + i, 0); put_enq(1, 0, 0, 1, 11 + 2*i, 40 + i, 7 + i); step();
    end
    for (int i = 1; i < 8; i += 3) begin
      for (int c = 0; c < 3; c++) if (i + c < 8) put_cpl(c, (b+i+c)&15, 0, 0, 0, 0, 0);
      step();
    end
    put_cpl(0, b, 0, 0, 0, 0, 0); step(); step();
    chk(free_cnt == 5'd14, "R4", "six per pass", free_cnt, 14);
    step();
    chk(free_cnt == 5'd16, "R4", "remaining two", free_cnt, 16);

    // R6 and R10: five correctly predicted speculative branches
    b = m_head;
    put_enq(0, 1, 0, 0, 0, 0, 0); put_enq(1, 1, 0, 0, 0, 0, 0); step();
    put_enq(0, 1, 0, 0, 0, 0, 0); put_enq(1, 1, 0, 0, 0, 0, 0); step();
    put_enq(0, 1, 0, 0, 0, 0, 0); step();
    for (int c = 0; c < 3; c++) put_cpl(c, (b+1+c)&15, 1, 1, 1, 0, 32'h100);
    step();
    put_cpl(0, (b+4)&15, 0, 0, 1, 0, 32'h200); step();
    put_cpl(0, b, 1, 1, 1, 0, 32'h300); step(); step();
    chk(free_cnt == 5'd14, "R6", "three spec per pass", free_cnt, 14);
    chk(!flush, "R10", "correct prediction no flush", flush, 0);
    step();
    chk(free_cnt == 5'd16, "R6", "rest next pass", free_cnt, 16);

    // R7: store ends the pass
    b = m_head;
    put_enq(0, 0, 0, 1, 12, 50, 13); put_enq(1, 0, 1, 0, 0, 0, 0); step();
    put_enq(0, 0, 0, 1, 14, 51, 15); step();
    for (int c = 0; c < 3; c++) put_cpl(c, (b+c)&15, 0, 0, 0, 0, 0);
    step(); step();
    chk(st_valid && st_tag == 4'((b+1)&15), "R7", "store strobe tag", {st_valid, st_tag}, {1'b1, 4'((b+1)&15)});
    chk(free_cnt == 5'd15, "R7", "stop after store", free_cnt, 15);
    step();
    chk(!st_valid && free_cnt == 5'd16, "R7", "next pass", {st_valid, free_cnt}, 16);

    // R8: mispredict flushes younger finished entries
    b = m_head; snap8 = m_map[8];
    put_enq(0, 1, 0, 1, 7, 40, 9); put_enq(1, 0, 0, 1, 8, 41, 0); step();
    put_enq(0, 0, 0, 1, 9, 42, 0); put_enq(1, 0, 0, 1, 10, 43, 0); step();
    for (int c = 0; c < 3; c++) put_cpl(c, (b+1+c)&15, 0, 0, 0, 0, 0);
    step();
    put_cpl(0, b, 1, 0, 1, 0, 32'h1234); step(); step();
    chk(flush && flush_pc == 32'h1234, "R8", "flush pc", flush_pc, 32'h1234);
    chk(free_cnt == 5'd16 && tail_ptr == 4'((b+1)&15), "R8", "emptied", {free_cnt, tail_ptr}, {5'd16, 4'((b+1)&15)});
    chk(commit_map[7*6 +: 6] == 6'd40, "R8", "mispredict dst committed", commit_map[7*6 +: 6], 40);
    chk(commit_map[8*6 +: 6] == 6'(snap8), "R8", "younger not committed", commit_map[8*6 +: 6], snap8);
    chk(rel_valid[0] && rel_preg[5:0] == 6'd9, "R5", "release slot 0", rel_preg[5:0], 9);
    step();
    chk(!flush && free_cnt == 5'd16, "R8", "stays empty", free_cnt, 16);

    // constrained random phase
    for (int i = 0; i < 2000; i++) begin
      gen_random(1'b1);
      step();
    end
    for (int i = 0; i < 300 && m_cnt > 0; i++) begin
      gen_random(1'b0);
      step();
    end
    step();

    // R9: fault at the head halts and holds
    b = m_head;
    put_enq(0, 0, 0, 1, 2, 60, 0); put_enq(1, 0, 0, 1, 3, 61, 0); step();
    put_cpl(0, (b+1)&15, 0, 0, 0, 0, 0); put_cpl(1, b, 0, 0, 0, 1, 0); step(); step();
    chk(halt && free_cnt == 5'd14, "R9", "halt raised", {halt, free_cnt}, {1'b1, 5'd14});
    step();
    chk(halt && free_cnt == 5'd14, "R9", "halt held", {halt, free_cnt}, {1'b1, 5'd14});
    finish_run();
  end
endmodule